// File: doc/BRIEF.md
# Packed Lane Operand Router

This block prepares the inputs of a packed arithmetic lane array. It takes two 128-bit packed operands, an operation select and a lane-width select, and for every result lane it emits a left element, a right element, a subtract flag and a lane-enable bit. The lane array then only adds or subtracts the pair in each lane. The routing can pair matching positions across the two operands, or neighbouring elements inside one operand. Even and odd lanes may also receive opposite operations.

The lanes are either four 32-bit elements (`wide_i` = 0) or two 64-bit elements (`wide_i` = 1). The three duplicate-move operations need no arithmetic, so the block builds their final 128-bit result itself and flags it with `dup_o`. A parameter (`INT_ALU`) places plain wrapping integer adders behind the routed bundles, so that `result_o` can be checked end to end without a floating-point unit. All outputs are registered. A request accepted with `in_valid_i` appears on the next clock edge.

Top module: `lane_route_unit`

## Requirements
- R1: With op_i = 0 and wide_i = 0, lane k (k = 0..3, 32 bits each, lane 0 in bits 31:0) routes lhs = a[k] and rhs = b[k]. Even lanes subtract and odd lanes add: sub_o = 4'b0101, where bit k = 1 means lhs minus rhs.
- R2: With op_i = 0 and wide_i = 1, the two 64-bit lanes (lane 0 in bits 63:0) route a[j] against b[j]. Lane 0 subtracts and lane 1 adds: sub_o = 4'b0001.
- R3: With op_i = 1 and wide_i = 0, the lhs lanes 0..3 are a0, a2, b0, b2 and the rhs lanes are a1, a3, b1, b3. sub_o = 0.
- R4: With op_i = 2 and wide_i = 0, the pairing is the same as in R3 but every lane subtracts (sub_o = 4'b1111). The lower-indexed element is always the minuend.
- R5: With wide_i = 1 and op_i = 1 (add) or op_i = 2 (subtract), lane 0 takes lhs = a0 and rhs = a1, and lane 1 takes lhs = b0 and rhs = b1. sub_o is 4'b0000 for add and 4'b0011 for subtract.
- R6: With wide_i = 0, op_i = 3 produces result b1, b1, b3, b3 in lanes 0..3 and op_i = 4 produces b0, b0, b2, b2. For both, dup_o = 1, lhs_o equals the result, rhs_o = 0 and sub_o = 0.
- R7: With op_i = 5 and wide_i = 1, both 64-bit halves of the result equal bits 63:0 of operand b. dup_o = 1.
- R8: lane_en_o is 4'b1111 for 32-bit lanes and 4'b0011 for 64-bit lanes.
- R9: Op codes 6 and 7, op 3 or 4 with wide_i = 1, and op 5 with wide_i = 0 are illegal. Such a request raises illegal_o for one cycle, keeps out_valid_o low, and leaves every registered output unchanged.
- R10: out_valid_o rises on the clock edge after an accepted legal request and stays high for exactly one cycle per request. Back-to-back requests produce back-to-back results in order.
- R11: While rst_ni is low, out_valid_o, illegal_o, lhs_o, rhs_o and result_o are all zero.
- R12: With INT_ALU = 1, each non-duplicate result lane equals lhs plus rhs, or lhs minus rhs when its sub bit is set, wrapping modulo 2^32 or 2^64 according to the lane width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request strobe; the inputs are captured when it is high |
| op_i | input | 3 | Operation select |
| wide_i | input | 1 | 0: four 32-bit lanes, 1: two 64-bit lanes |
| opa_i | input | 128 | Operand a |
| opb_i | input | 128 | Operand b |
| out_valid_o | output | 1 | Routed output valid, one-cycle pulse |
| illegal_o | output | 1 | Illegal request pulse |
| lhs_o | output | 128 | Left element for each lane |
| rhs_o | output | 128 | Right element for each lane |
| sub_o | output | 4 | Per-lane subtract flag |
| lane_en_o | output | 4 | Per-lane enable |
| dup_o | output | 1 | Result is a finished duplicate move |
| result_o | output | 128 | Duplicate result, or the integer lane result when INT_ALU = 1 |

## Verification
The bench targets three kinds of fault: minuend order in the horizontal subtract modes, the parity of the alternating mode, and the lane boundaries of the 64-bit modes. Subtraction values are chosen to wrap, so a swapped pair or a flipped parity changes `result_o` visibly instead of cancelling out. The duplicate moves are checked with distinct elements in every lane, so picking an odd element where an even one is due (or the other way round) shows up. Illegal width and op combinations are sent after a known good result. A design that latched them, or let them pulse valid, would alter the held outputs. Back-to-back requests catch a stage that drops or reorders results.

// File: rtl/lane_route_pkg.sv
package lane_route_pkg;
  typedef enum logic [2:0] {
    OP_ADDSUB   = 3'd0,
    OP_HADD     = 3'd1,
    OP_HSUB     = 3'd2,
    OP_DUP_ODD  = 3'd3,
    OP_DUP_EVEN = 3'd4,
    OP_DUP_WIDE = 3'd5
  } lane_op_e;

  function automatic logic op_legal(input logic [2:0] op, input logic wide);
    case (op)
      OP_ADDSUB, OP_HADD, OP_HSUB: op_legal = 1'b1;
      OP_DUP_ODD, OP_DUP_EVEN:     op_legal = !wide;
      OP_DUP_WIDE:                 op_legal = wide;
      default:                     op_legal = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/lane_route_mux.sv
module lane_route_mux
  import lane_route_pkg::*;
#(
  parameter int ELEM_W = 32,
  parameter int LANES  = 4
) (
  input  logic [2:0]              op_i,
  input  logic                    wide_i,
  input  logic [ELEM_W*LANES-1:0] a_i,
  input  logic [ELEM_W*LANES-1:0] b_i,
  output logic [ELEM_W*LANES-1:0] lhs_o,
  output logic [ELEM_W*LANES-1:0] rhs_o,
  output logic [LANES-1:0]        sub_o,
  output logic [LANES-1:0]        en_o,
  output logic                    dup_o,
  output logic                    legal_o
);
  localparam int VEC_W  = ELEM_W * LANES;
  localparam int WIDE_W = 2 * ELEM_W;
  localparam int WL     = LANES / 2;
  localparam int HALF   = LANES / 2;
  localparam int WHALF  = WL / 2;

  logic [ELEM_W-1:0] na [LANES];
  logic [ELEM_W-1:0] nb [LANES];
  logic [WIDE_W-1:0] wa [WL];
  logic [WIDE_W-1:0] wb [WL];

  logic [VEC_W-1:0] hl_n, hr_n, dodd_n, deven_n;
  logic [VEC_W-1:0] hl_w, hr_w, dup_w;
  logic [LANES-1:0] alt_n, alt_w, low_en;

  for (genvar k = 0; k < LANES; k++) begin : g_narrow
    assign na[k]     = a_i[k*ELEM_W +: ELEM_W];
    assign nb[k]     = b_i[k*ELEM_W +: ELEM_W];
    assign alt_n[k]  = (k % 2 == 0);
    assign alt_w[k]  = (k < WL) && (k % 2 == 0);
    assign low_en[k] = (k < WL);
    if (k < HALF) begin : g_lo
      assign hl_n[k*ELEM_W +: ELEM_W] = na[2*k];
      assign hr_n[k*ELEM_W +: ELEM_W] = na[2*k+1];
    end else begin : g_hi
      assign hl_n[k*ELEM_W +: ELEM_W] = nb[2*(k-HALF)];
      assign hr_n[k*ELEM_W +: ELEM_W] = nb[2*(k-HALF)+1];
    end
    assign dodd_n[k*ELEM_W +: ELEM_W]  = nb[(k/2)*2+1];
    assign deven_n[k*ELEM_W +: ELEM_W] = nb[(k/2)*2];
  end

  for (genvar j = 0; j < WL; j++) begin : g_wide
    assign wa[j] = a_i[j*WIDE_W +: WIDE_W];
    assign wb[j] = b_i[j*WIDE_W +: WIDE_W];
    if (j < WHALF || WL == 1) begin : g_lo
      assign hl_w[j*WIDE_W +: WIDE_W] = wa[(2*j) % WL];
      assign hr_w[j*WIDE_W +: WIDE_W] = wa[(2*j+1) % WL];
    end else begin : g_hi
      assign hl_w[j*WIDE_W +: WIDE_W] = wb[2*(j-WHALF)];
      assign hr_w[j*WIDE_W +: WIDE_W] = wb[2*(j-WHALF)+1];
    end
    assign dup_w[j*WIDE_W +: WIDE_W] = wb[0];
  end

  always_comb begin
    lhs_o   = a_i;
    rhs_o   = b_i;
    sub_o   = '0;
    en_o    = wide_i ? low_en : '1;
    dup_o   = 1'b0;
    legal_o = op_legal(op_i, wide_i);
    case (op_i)
      OP_ADDSUB: sub_o = wide_i ? alt_w : alt_n;
      OP_HADD: begin
        lhs_o = wide_i ? hl_w : hl_n;
        rhs_o = wide_i ? hr_w : hr_n;
      end
      OP_HSUB: begin
        lhs_o = wide_i ? hl_w : hl_n;
        rhs_o = wide_i ? hr_w : hr_n;
        sub_o = wide_i ? low_en : '1;
      end
      OP_DUP_ODD: begin
        lhs_o = dodd_n;
        rhs_o = '0;
        dup_o = 1'b1;
      end
      OP_DUP_EVEN: begin
        lhs_o = deven_n;
        rhs_o = '0;
        dup_o = 1'b1;
      end
      OP_DUP_WIDE: begin
        lhs_o = dup_w;
        rhs_o = '0;
        dup_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lane_int_alu.sv
module lane_int_alu #(
  parameter int ELEM_W = 32,
  parameter int LANES  = 4
) (
  input  logic                    wide_i,
  input  logic [ELEM_W*LANES-1:0] lhs_i,
  input  logic [ELEM_W*LANES-1:0] rhs_i,
  input  logic [LANES-1:0]        sub_i,
  output logic [ELEM_W*LANES-1:0] res_o
);
  localparam int VEC_W  = ELEM_W * LANES;
  localparam int WIDE_W = 2 * ELEM_W;
  localparam int WL     = LANES / 2;

  logic [VEC_W-1:0] n_res, w_res;

  for (genvar k = 0; k < LANES; k++) begin : g_n
    assign n_res[k*ELEM_W +: ELEM_W] = sub_i[k]
      ? lhs_i[k*ELEM_W +: ELEM_W] - rhs_i[k*ELEM_W +: ELEM_W]
      : lhs_i[k*ELEM_W +: ELEM_W] + rhs_i[k*ELEM_W +: ELEM_W];
  end

  for (genvar j = 0; j < WL; j++) begin : g_w
    assign w_res[j*WIDE_W +: WIDE_W] = sub_i[j]
      ? lhs_i[j*WIDE_W +: WIDE_W] - rhs_i[j*WIDE_W +: WIDE_W]
      : lhs_i[j*WIDE_W +: WIDE_W] + rhs_i[j*WIDE_W +: WIDE_W];
  end

  assign res_o = wide_i ? w_res : n_res;
endmodule

// File: rtl/lane_route_unit.sv
module lane_route_unit #(
  parameter int ELEM_W  = 32,
  parameter int LANES   = 4,
  parameter bit INT_ALU = 1'b1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  input  logic [2:0]              op_i,
  input  logic                    wide_i,
  input  logic [ELEM_W*LANES-1:0] opa_i,
  input  logic [ELEM_W*LANES-1:0] opb_i,
  output logic                    out_valid_o,
  output logic                    illegal_o,
  output logic [ELEM_W*LANES-1:0] lhs_o,
  output logic [ELEM_W*LANES-1:0] rhs_o,
  output logic [LANES-1:0]        sub_o,
  output logic [LANES-1:0]        lane_en_o,
  output logic                    dup_o,
  output logic [ELEM_W*LANES-1:0] result_o
);
  localparam int VEC_W = ELEM_W * LANES;

  logic [VEC_W-1:0] lhs_d, rhs_d, lhs_q, rhs_q, alu_res;
  logic [LANES-1:0] sub_d, en_d, sub_q, en_q;
  logic             dup_d, dup_q, legal_d, wide_q, valid_q, illegal_q;

  lane_route_mux #(.ELEM_W(ELEM_W), .LANES(LANES)) u_mux (
    .op_i    (op_i),
    .wide_i  (wide_i),
    .a_i     (opa_i),
    .b_i     (opb_i),
    .lhs_o   (lhs_d),
    .rhs_o   (rhs_d),
    .sub_o   (sub_d),
    .en_o    (en_d),
    .dup_o   (dup_d),
    .legal_o (legal_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
      lhs_q     <= '0;
      rhs_q     <= '0;
      sub_q     <= '0;
      en_q      <= '0;
      dup_q     <= 1'b0;
      wide_q    <= 1'b0;
    end else begin
      valid_q   <= in_valid_i && legal_d;
      illegal_q <= in_valid_i && !legal_d;
      if (in_valid_i && legal_d) begin
        lhs_q  <= lhs_d;
        rhs_q  <= rhs_d;
        sub_q  <= sub_d;
        en_q   <= en_d;
        dup_q  <= dup_d;
        wide_q <= wide_i;
      end
    end
  end

  if (INT_ALU) begin : g_alu
    lane_int_alu #(.ELEM_W(ELEM_W), .LANES(LANES)) u_alu (
      .wide_i (wide_q),
      .lhs_i  (lhs_q),
      .rhs_i  (rhs_q),
      .sub_i  (sub_q),
      .res_o  (alu_res)
    );
  end else begin : g_no_alu
    assign alu_res = '0;
  end

  assign out_valid_o = valid_q;
  assign illegal_o   = illegal_q;
  assign lhs_o       = lhs_q;
  assign rhs_o       = rhs_q;
  assign sub_o       = sub_q;
  assign lane_en_o   = en_q;
  assign dup_o       = dup_q;
  assign result_o    = dup_q ? lhs_q : alu_res;
endmodule

// File: rtl/lane_route_chk.sv
module lane_route_chk #(
  parameter int ELEM_W = 32,
  parameter int LANES  = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    in_valid_i,
  input logic [2:0]              op_i,
  input logic                    wide_i,
  input logic                    out_valid_o,
  input logic                    illegal_o,
  input logic [ELEM_W*LANES-1:0] lhs_o,
  input logic [ELEM_W*LANES-1:0] rhs_o,
  input logic [LANES-1:0]        sub_o,
  input logic [LANES-1:0]        lane_en_o,
  input logic                    dup_o
);
  localparam int WIDE_W = 2 * ELEM_W;
  localparam logic [LANES-1:0] LOW_EN = LANES'((1 << (LANES/2)) - 1);

  AST_VALID_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> (!out_valid_o && !illegal_o)); // R10
  AST_VALID_XOR_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(out_valid_o && illegal_o)); // R9
  AST_ILLEGAL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> ($stable(lhs_o) && $stable(rhs_o) && $stable(sub_o))); // R9
  AST_LANE_EN_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (lane_en_o == '1 || lane_en_o == LOW_EN)); // R8
  AST_ALT_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && $past(op_i) == 3'd0) |-> (sub_o[0] && !sub_o[1])); // R1
  AST_HSUB_MINUEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && $past(op_i) == 3'd2 && !$past(wide_i)) |-> sub_o == '1); // R4
  AST_DUP_NO_SUB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && dup_o) |-> sub_o == '0); // R6
  AST_DUP_WIDE_HALVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && $past(op_i) == 3'd5) |->
      lhs_o[0 +: WIDE_W] == lhs_o[WIDE_W +: WIDE_W]); // R7
endmodule

bind lane_route_unit lane_route_chk #(.ELEM_W(ELEM_W), .LANES(LANES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .op_i        (op_i),
  .wide_i      (wide_i),
  .out_valid_o (out_valid_o),
  .illegal_o   (illegal_o),
  .lhs_o       (lhs_o),
  .rhs_o       (rhs_o),
  .sub_o       (sub_o),
  .lane_en_o   (lane_en_o),
  .dup_o       (dup_o)
);

// File: tb/lane_route_unit_tb.sv
module lane_route_unit_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid_i = 1'b0;
  logic [2:0]   op_i = '0;
  logic         wide_i = 1'b0;
  logic [127:0] opa_i = '0, opb_i = '0;
  logic         out_valid_o, illegal_o, dup_o;
  logic [127:0] lhs_o, rhs_o, result_o;
  logic [3:0]   sub_o, lane_en_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  lane_route_unit u_dut (
    .clk_i, .rst_ni, .in_valid_i, .op_i, .wide_i, .opa_i, .opb_i,
    .out_valid_o, .illegal_o, .lhs_o, .rhs_o, .sub_o, .lane_en_o,
    .dup_o, .result_o
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] el(input logic [127:0] v, input int k);
    return v[k*32 +: 32];
  endfunction

  function automatic logic [63:0] wel(input logic [127:0] v, input int j);
    return v[j*64 +: 64];
  endfunction

  task automatic issue(input logic [2:0] op, input logic wide,
                       input logic [127:0] a, input logic [127:0] b);
    @(negedge clk_i);
    op_i = op; wide_i = wide; opa_i = a; opb_i = b; in_valid_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  // expected arithmetic result from routed pairs (R12)
  function automatic logic [127:0] arith(input logic wide, input logic [127:0] l,
                                         input logic [127:0] r, input logic [3:0] s);
    logic [127:0] v;
    v = '0;
    if (wide) begin
      for (int j = 0; j < 2; j++)
        v[j*64 +: 64] = s[j] ? wel(l,j) - wel(r,j) : wel(l,j) + wel(r,j);
    end else begin
      for (int k = 0; k < 4; k++)
        v[k*32 +: 32] = s[k] ? el(l,k) - el(r,k) : el(l,k) + el(r,k);
    end
    return v;
  endfunction

  task automatic check_arith(input string req, input logic wide, input logic [127:0] el_l,
                             input logic [127:0] el_r, input logic [3:0] el_s);
    chk({req, " valid"}, 128'(out_valid_o), 128'd1);
    chk({req, " lhs"}, lhs_o, el_l);
    chk({req, " rhs"}, rhs_o, el_r);
    chk({req, " sub"}, 128'(sub_o), 128'(el_s));
    chk({req, " R8 en"}, 128'(lane_en_o), wide ? 128'h3 : 128'hf);
    chk({req, " R12 result"}, result_o, arith(wide, el_l, el_r, el_s));
    chk({req, " dup"}, 128'(dup_o), 128'd0);
  endtask

  task automatic t_reset;
    chk("R11 valid", 128'(out_valid_o), 128'd0);
    chk("R11 illegal", 128'(illegal_o), 128'd0);
    chk("R11 lhs", lhs_o, '0);
    chk("R11 rhs", rhs_o, '0);
    chk("R11 result", result_o, '0);
  endtask

  task automatic t_alt;
    logic [127:0] a, b;
    a = {32'h4000_0004, 32'h3000_0003, 32'h2000_0002, 32'h0000_0001};
    b = {32'h0400_0040, 32'h0300_0030, 32'h1000_0020, 32'h0000_0005};
    issue(3'd0, 1'b0, a, b);
    check_arith("R1 alt32", 1'b0, a, b, 4'b0101);
    a = {64'h0000_0000_0000_0010, 64'h0000_0000_0000_0001};
    b = {64'hffff_ffff_ffff_fff0, 64'h0000_0000_0000_0002};
    issue(3'd0, 1'b1, a, b);
    check_arith("R2 alt64", 1'b1, a, b, 4'b0001);
  endtask

  task automatic t_horiz32;
    logic [127:0] a, b, l, r;
    a = {32'h0000_0044, 32'h0000_0033, 32'h0000_0022, 32'h0000_0011};
    b = {32'h0000_0808, 32'h0000_0707, 32'h0000_0606, 32'h0000_0505};
    l = {el(b,2), el(b,0), el(a,2), el(a,0)};
    r = {el(b,3), el(b,1), el(a,3), el(a,1)};
    issue(3'd1, 1'b0, a, b);
    check_arith("R3 hadd32", 1'b0, l, r, 4'b0000);
    issue(3'd2, 1'b0, a, b);
    check_arith("R4 hsub32", 1'b0, l, r, 4'b1111);
  endtask

  task automatic t_horiz64;
    logic [127:0] a, b, l, r;
    a = {64'h0000_0000_0000_0300, 64'h0000_0000_0000_0100};
    b = {64'h0000_0001_0000_0000, 64'h0000_0000_0000_0007};
    l = {wel(b,0), wel(a,0)};
    r = {wel(b,1), wel(a,1)};
    issue(3'd1, 1'b1, a, b);
    check_arith("R5 hadd64", 1'b1, l, r, 4'b0000);
    issue(3'd2, 1'b1, a, b);
    check_arith("R5 hsub64", 1'b1, l, r, 4'b0011);
  endtask

  task automatic t_dup;
    logic [127:0] a, b, e;
    a = {4{32'hdead_beef}};
    b = {32'hb333_3333, 32'hb222_2222, 32'hb111_1111, 32'hb000_0000};
    issue(3'd3, 1'b0, a, b);
    e = {el(b,3), el(b,3), el(b,1), el(b,1)};
    chk("R6 dup odd result", result_o, e);
    chk("R6 dup odd lhs", lhs_o, e);
    chk("R6 dup odd rhs", rhs_o, '0);
    chk("R6 dup odd flag", 128'(dup_o), 128'd1);
    chk("R6 dup odd sub", 128'(sub_o), 128'd0);
    issue(3'd4, 1'b0, a, b);
    e = {el(b,2), el(b,2), el(b,0), el(b,0)};
    chk("R6 dup even result", result_o, e);
    chk("R8 dup even en", 128'(lane_en_o), 128'hf);
    issue(3'd5, 1'b1, a, b);
    e = {wel(b,0), wel(b,0)};
    chk("R7 dup64 result", result_o, e);
    chk("R7 dup64 flag", 128'(dup_o), 128'd1);
    chk("R7 dup64 valid", 128'(out_valid_o), 128'd1);
    chk("R8 dup64 en", 128'(lane_en_o), 128'h3);
  endtask

  task automatic t_illegal;
    logic [127:0] pl, pr, pres;
    logic [3:0] psub;
    logic [2:0] ops [4] = '{3'd6, 3'd7, 3'd3, 3'd5};
    logic       wds [4] = '{1'b0, 1'b1, 1'b1, 1'b0};
    issue(3'd0, 1'b0, {4{32'h1234_5678}}, {4{32'h0101_0101}});
    pl = lhs_o; pr = rhs_o; pres = result_o; psub = sub_o;
    for (int i = 0; i < 4; i++) begin
      issue(ops[i], wds[i], {4{32'hffff_0000}}, {4{32'h0000_ffff}});
      chk("R9 illegal flag", 128'(illegal_o), 128'd1);
      chk("R9 valid low", 128'(out_valid_o), 128'd0);
      chk("R9 lhs held", lhs_o, pl);
      chk("R9 rhs held", rhs_o, pr);
      chk("R9 sub held", 128'(sub_o), 128'(psub));
      chk("R9 result held", result_o, pres);
    end
    @(negedge clk_i);
    chk("R9 illegal one cycle", 128'(illegal_o), 128'd0);
  endtask

  task automatic t_timing;
    logic [127:0] a1, a2, b;
    a1 = {32'd4, 32'd3, 32'd2, 32'd1};
    a2 = {32'd40, 32'd30, 32'd20, 32'd10};
    b  = '0;
    @(negedge clk_i);
    op_i = 3'd1; wide_i = 1'b0; opa_i = a1; opb_i = b; in_valid_i = 1'b1;
    @(negedge clk_i);
    opa_i = a2;
    chk("R10 first valid", 128'(out_valid_o), 128'd1);
    chk("R10 first data", result_o, {32'd0, 32'd0, 32'd7, 32'd3});
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk("R10 second valid", 128'(out_valid_o), 128'd1);
    chk("R10 second data", result_o, {32'd0, 32'd0, 32'd70, 32'd30});
    @(negedge clk_i);
    chk("R10 valid drops", 128'(out_valid_o), 128'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_alt();
    t_horiz32();
    t_horiz64();
    t_dup();
    t_illegal();
    t_timing();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule